// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is a one-channel direct memory access mover. Software sets up a source address, a destination address, a unit count and, for each side, whether the address advances or stays fixed. Software then sets a start bit. The engine takes the shared bus through a request/grant handshake and moves data one unit at a time. Each unit is a read from the source followed by a write to the destination. The addresses and the remaining count are updated in hardware as part of the write cycle, so no extra cycles are spent on bookkeeping. A peripheral data register is addressed by holding its side fixed, while a memory buffer uses the advancing side.

Three transfer modes set how long the engine keeps the bus:
- **Single mode** gives the bus back after every unit, so processor cycles fall between transfer cycles.
- **Demand mode** keeps moving data while the peripheral asks for it. It frees the bus whenever that request drops, and resumes when the request returns.
- **Block mode** keeps the bus from start to finish and does not look at the peripheral request.

In every mode, an external end-of-process input or the count reaching zero ends the channel. The end is reported by a sticky status bit and a one-cycle pulse.

Top module: `dma_mover`

## Requirements
- R1: Each unit is one bus cycle with `bus_rd` high at the source address, followed by one bus cycle with `bus_wr` high at the destination address. The read data is taken from `bus_rdata` in the same cycle as `bus_rd`, and that value is driven on `bus_wdata` during the write.
- R2: Control bit 3 (source) and control bit 4 (destination) enable address stepping for their side. An enabled side advances by DW/8 when `BYTE_ADDR` is 1, or by 1 otherwise, after each unit's write. A disabled side keeps its address. Register offsets 0 (source) and 1 (destination) read back the live addresses.
- R3: The count register (offset 2) drops by one on each unit's write and reads back the units still to move. The channel ends when the count reaches zero.
- R4: Control bits [2:1] = 00 select single mode. A unit starts only while `per_req` is high, and `bus_req` goes low for at least one cycle after every unit.
- R5: Control bits [2:1] = 01 select demand mode. Units run back to back while `per_req` stays high. When `per_req` is low at a unit boundary, the engine drops `bus_req` and makes no strobes, but stays busy. It resumes when `per_req` returns.
- R6: Control bits [2:1] = 10 (or 11) select block mode. The engine ignores `per_req` and keeps `bus_req` high from its first request until the channel ends.
- R7: When `eop` is high while the channel is busy, the channel ends after the unit in progress. If no unit is in progress, it ends at once. The count register keeps the number of units not moved.
- R8: Writing offset 3 with bit 0 set starts the channel, and the same write sets mode and step flags. Reading offset 3 returns done in bit 5 and busy in bit 6. Done clears on start and sets when the channel ends, and `done_pulse` is high for exactly the first cycle after the end.
- R9: Register writes made while the channel is busy change no register, including a start request.
- R10: `bus_req` is low whenever the channel is idle. `bus_rd` and `bus_wr` are high only while `bus_gnt` is high, and a unit waits without strobes while grant is withheld.
- R11: Starting with a count of zero ends the channel on the start edge: `done_pulse` is high in the next cycle, and `bus_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register offset: 0 source, 1 destination, 2 count, 3 control/status |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data for `cfg_addr` |
| per_req | input | 1 | Peripheral transfer request |
| eop | input | 1 | External end-of-process |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in the `bus_rd` cycle |
| done_pulse | output | 1 | One-cycle end-of-channel pulse |

## Verification
The bench builds the engine with a 16-bit data path, 16-bit addresses, an 8-bit count and byte addressing. This makes every enabled address step 2, so the bench can tell stepping apart from holding and from a step of one. The bench memory returns a fresh value at a fixed peripheral address on each read and logs every write made there. This lets it check hold-side transfers in both directions, in order. Grant is under the bench's control, so stalls with strobes withheld and writes made while busy can be checked.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [1:0] {
      XM_SINGLE = 2'b00,
      XM_DEMAND = 2'b01,
      XM_BLOCK  = 2'b10,
      XM_RSVD   = 2'b11
   } xfer_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ARB,
      SQ_READ,
      SQ_WRITE,
      SQ_REST
   } seq_state_e;

   localparam logic [1:0] REG_SRC = 2'd0;
   localparam logic [1:0] REG_DST = 2'd1;
   localparam logic [1:0] REG_CNT = 2'd2;
   localparam logic [1:0] REG_CTL = 2'd3;

   localparam int unsigned CTL_GO      = 0;
   localparam int unsigned CTL_MODE_LO = 1;
   localparam int unsigned CTL_MODE_HI = 2;
   localparam int unsigned CTL_SINC    = 3;
   localparam int unsigned CTL_DINC    = 4;
   localparam int unsigned ST_DONE     = 5;
   localparam int unsigned ST_BUSY     = 6;
   localparam int unsigned CTL_WIDTH   = 7;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int unsigned AW   = 32,
   parameter int unsigned STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          advance,
   input  logic          inc_en,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] next_addr;

   generate
      if (STEP == 1) begin : g_unit
         assign next_addr = addr + 1'b1;
      end else begin : g_wide
         assign next_addr = addr + AW'(STEP);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (advance && inc_en) begin
         addr <= next_addr;
      end
   end

endmodule

// File: rtl/dma_unit_count.sv
module dma_unit_count #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] count,
   output logic          is_zero,
   output logic          is_last
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (dec && !is_zero) begin
         count <= count - 1'b1;
      end
   end

   assign is_zero = (count == '0);
   assign is_last = (count == CW'(1));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       cnt_zero,
   input  logic       cnt_last,
   input  xfer_mode_e mode,
   input  logic       per_req,
   input  logic       eop,
   input  logic       bus_gnt,
   output logic       bus_req,
   output logic       rd_stb,
   output logic       wr_stb,
   output logic       finish,
   output logic       busy,
   output logic       sel_dst
);

   seq_state_e state_q, state_d;
   logic       eop_pend_q;
   logic       eop_now;
   logic       want_bus;

   assign busy     = (state_q != SQ_IDLE);
   assign sel_dst  = (state_q == SQ_WRITE);
   assign eop_now  = eop_pend_q | eop;
   assign want_bus = (mode == XM_BLOCK) || (mode == XM_RSVD) || per_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eop_pend_q <= 1'b0;
      end else if (launch) begin
         eop_pend_q <= 1'b0;
      end else if (busy && eop) begin
         eop_pend_q <= 1'b1;
      end
   end

   always_comb begin
      state_d = state_q;
      bus_req = 1'b0;
      rd_stb  = 1'b0;
      wr_stb  = 1'b0;
      finish  = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (launch) begin
               if (cnt_zero) begin
                  finish = 1'b1;
               end else begin
                  state_d = SQ_ARB;
               end
            end
         end
         SQ_ARB: begin
            if (eop_now) begin
               finish  = 1'b1;
               state_d = SQ_IDLE;
            end else begin
               bus_req = want_bus;
               if (want_bus && bus_gnt) begin
                  state_d = SQ_READ;
               end
            end
         end
         SQ_READ: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               rd_stb  = 1'b1;
               state_d = SQ_WRITE;
            end
         end
         SQ_WRITE: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               wr_stb = 1'b1;
               if (cnt_last || eop_now) begin
                  finish  = 1'b1;
                  state_d = SQ_IDLE;
               end else begin
                  unique case (mode)
                     XM_SINGLE: state_d = SQ_REST;
                     XM_DEMAND: state_d = per_req ? SQ_READ : SQ_ARB;
                     default:   state_d = SQ_READ;
                  endcase
               end
            end
         end
         SQ_REST: begin
            state_d = SQ_ARB;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
   import dma_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 32,
   parameter int unsigned CW        = 16,
   parameter int unsigned RW        = 32,
   parameter bit          BYTE_ADDR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [RW-1:0] cfg_wdata,
   output logic [RW-1:0] cfg_rdata,
   input  logic          per_req,
   input  logic          eop,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          done_pulse
);

   localparam int unsigned STEP  = BYTE_ADDR ? (DW / 8) : 1;
   localparam int unsigned NSIDE = 2;

   generate
      if (AW > RW) begin : g_bad_aw
         $error("dma_mover: AW must not exceed RW");
      end
      if (CW > RW || CW < 1) begin : g_bad_cw
         $error("dma_mover: CW must be in 1..RW");
      end
      if (RW < CTL_WIDTH) begin : g_bad_rw
         $error("dma_mover: RW too narrow for control register");
      end
      if (BYTE_ADDR && (DW < 8 || (DW % 8) != 0)) begin : g_bad_dw
         $error("dma_mover: byte addressing needs DW a multiple of 8");
      end
   endgenerate

   logic             busy;
   logic             launch;
   logic             finish;
   logic             rd_stb;
   logic             wr_stb;
   logic             sel_dst;
   logic             cnt_zero;
   logic             cnt_last;
   logic             reg_wr;
   logic             done_q;
   xfer_mode_e       mode_q;
   logic [NSIDE-1:0] inc_q;
   logic [AW-1:0]    side_addr [NSIDE];
   logic [CW-1:0]    cnt_val;
   logic [DW-1:0]    data_q;

   assign reg_wr = cfg_we && !busy;
   assign launch = reg_wr && (cfg_addr == REG_CTL) && cfg_wdata[CTL_GO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= XM_SINGLE;
         inc_q  <= '0;
      end else if (reg_wr && cfg_addr == REG_CTL) begin
         mode_q <= xfer_mode_e'(cfg_wdata[CTL_MODE_HI:CTL_MODE_LO]);
         inc_q  <= cfg_wdata[CTL_DINC:CTL_SINC];
      end
   end

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         localparam logic [1:0] SEL = (s == 0) ? REG_SRC : REG_DST;
         dma_addr_step #(
            .AW   (AW),
            .STEP (STEP)
         ) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (reg_wr && (cfg_addr == SEL)),
            .load_val (cfg_wdata[AW-1:0]),
            .advance  (wr_stb),
            .inc_en   (inc_q[s]),
            .addr     (side_addr[s])
         );
      end
   endgenerate

   dma_unit_count #(
      .CW (CW)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reg_wr && (cfg_addr == REG_CNT)),
      .load_val (cfg_wdata[CW-1:0]),
      .dec      (wr_stb),
      .count    (cnt_val),
      .is_zero  (cnt_zero),
      .is_last  (cnt_last)
   );

   dma_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .mode     (mode_q),
      .per_req  (per_req),
      .eop      (eop),
      .bus_gnt  (bus_gnt),
      .bus_req  (bus_req),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .finish   (finish),
      .busy     (busy),
      .sel_dst  (sel_dst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q     <= '0;
         done_q     <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         if (rd_stb) begin
            data_q <= bus_rdata;
         end
         if (finish) begin
            done_q <= 1'b1;
         end else if (launch) begin
            done_q <= 1'b0;
         end
         done_pulse <= finish;
      end
   end

   assign bus_addr  = sel_dst ? side_addr[1] : side_addr[0];
   assign bus_rd    = rd_stb;
   assign bus_wr    = wr_stb;
   assign bus_wdata = data_q;

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_addr)
         REG_SRC: cfg_rdata = RW'(side_addr[0]);
         REG_DST: cfg_rdata = RW'(side_addr[1]);
         REG_CNT: cfg_rdata = RW'(cnt_val);
         default: begin
            cfg_rdata[CTL_MODE_HI:CTL_MODE_LO] = mode_q;
            cfg_rdata[CTL_SINC]                = inc_q[0];
            cfg_rdata[CTL_DINC]                = inc_q[1];
            cfg_rdata[ST_DONE]                 = done_q;
            cfg_rdata[ST_BUSY]                 = busy;
         end
      endcase
   end

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_rd,
   input logic          bus_wr,
   input logic          busy,
   input logic          done_q,
   input logic          done_pulse,
   input logic [1:0]    mode_q,
   input logic [CW-1:0] cnt_val
);

   // R10
   strobe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_gnt && bus_req));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_req && !bus_rd && !bus_wr));

   // R1
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R1
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd);

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (cnt_val == $past(cnt_val) - CW'(1)));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_wr) |=> $stable(cnt_val));

   // R4
   single_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mode_q == 2'b00) |=> !bus_req);

   // R6
   block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_req && mode_q[1]) |=> (bus_req || !busy));

   // R8
   pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!busy && done_q));

endmodule

bind dma_mover dma_mover_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_dma_mover.sv
module sim_dma_mover;

   localparam int unsigned DW = 16;
   localparam int unsigned AW = 16;
   localparam int unsigned CW = 8;
   localparam int unsigned RW = 32;
   localparam logic [AW-1:0] PER_A = 16'h1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = 2'd0;
   logic [RW-1:0] cfg_wdata = '0;
   logic [RW-1:0] cfg_rdata;
   logic          per_req = 1'b0;
   logic          eop = 1'b0;
   logic          bus_req;
   logic          bus_gnt;
   logic [AW-1:0] bus_addr;
   logic          bus_rd;
   logic          bus_wr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          done_pulse;

   logic          gnt_allow = 1'b1;
   logic [DW-1:0] mem [256];
   logic [DW-1:0] per_val = '0;
   logic [DW-1:0] per_log [16];
   int            log_n = 0;
   int            rd_cnt = 0;
   int            wr_cnt = 0;
   int            drops = 0;
   int            req_hi = 0;
   logic          prev_req = 1'b0;
   int            checks = 0;
   int            errors = 0;
   int            cyc = 0;

   always #2 clk = ~clk;

   dma_mover #(
      .DW(DW), .AW(AW), .CW(CW), .RW(RW), .BYTE_ADDR(1'b1)
   ) u0 (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .per_req, .eop, .bus_req, .bus_gnt, .bus_addr, .bus_rd, .bus_wr,
      .bus_wdata, .bus_rdata, .done_pulse
   );

   assign bus_gnt   = bus_req & gnt_allow;
   assign bus_rdata = (bus_addr == PER_A) ? per_val : mem[bus_addr[8:1]];

   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (bus_addr == PER_A) per_val <= per_val + 1'b1;
         end
         if (bus_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (bus_addr == PER_A) begin
               per_log[log_n[3:0]] <= bus_wdata;
               log_n <= log_n + 1;
            end else begin
               mem[bus_addr[8:1]] <= bus_wdata;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (prev_req && !bus_req && !done_pulse) drops <= drops + 1;
      if (bus_req) req_hi <= req_hi + 1;
      prev_req <= bus_req;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic clear_mon();
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; drops = 0; req_hi = 0; log_n = 0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (done_pulse !== 1'b1 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " completion pulse"}, {31'd0, done_pulse}, 32'd1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R10 reset bus_req", {31'd0, bus_req}, 32'd0);
      chk("R10 reset strobes", {30'd0, bus_rd, bus_wr}, 32'd0);
      chk("R8 reset pulse", {31'd0, done_pulse}, 32'd0);
      rd_reg(2'd3, v);
      chk("R8 reset busy/done", {30'd0, v[6], v[5]}, 32'd0);
      rd_reg(2'd2, v);
      chk("R3 reset count", v, 32'd0);
   endtask

   task automatic t_block();
      logic [31:0] v;
      clear_mon();
      per_req = 1'b0;
      wr_reg(2'd0, 32'h0040);
      wr_reg(2'd1, 32'h0100);
      wr_reg(2'd2, 32'd5);
      wr_reg(2'd3, 32'h1D);
      wait_done("R6 block");
      for (int k = 0; k < 5; k++)
         chk("R1 block data", {16'd0, mem[8'h80 + k]}, {16'd0, 16'hA020 + 16'(k)});
      chk("R1 read count", rd_cnt, 5);
      chk("R1 write count", wr_cnt, 5);
      chk("R6 no release in block", drops, 0);
      rd_reg(2'd0, v);
      chk("R2 src stepped by 2", v, 32'h004A);
      rd_reg(2'd1, v);
      chk("R2 dst stepped by 2", v, 32'h010A);
      rd_reg(2'd2, v);
      chk("R3 count at zero", v, 32'd0);
      rd_reg(2'd3, v);
      chk("R8 done set busy clear", {30'd0, v[6], v[5]}, 32'd1);
   endtask

   task automatic t_single();
      logic [31:0] v;
      clear_mon();
      per_val = 16'h5500;
      per_req = 1'b1;
      wr_reg(2'd0, {16'd0, PER_A});
      wr_reg(2'd1, 32'h0180);
      wr_reg(2'd2, 32'd3);
      wr_reg(2'd3, 32'h11);
      wait_done("R4 single");
      for (int k = 0; k < 3; k++)
         chk("R4 single data", {16'd0, mem[8'hC0 + k]}, {16'd0, 16'h5500 + 16'(k)});
      chk("R4 release after each unit", drops, 2);
      rd_reg(2'd0, v);
      chk("R2 held src", v, {16'd0, PER_A});
      rd_reg(2'd1, v);
      chk("R2 dst stepped", v, 32'h0186);
      per_req = 1'b0;
   endtask

   task automatic t_demand();
      logic [31:0] v;
      int n = 0;
      clear_mon();
      per_req = 1'b1;
      wr_reg(2'd0, 32'h0060);
      wr_reg(2'd1, {16'd0, PER_A});
      wr_reg(2'd2, 32'd4);
      wr_reg(2'd3, 32'h0B);
      while (!(bus_wr === 1'b1 && wr_cnt == 1) && n < 100) begin
         @(negedge clk);
         n++;
      end
      per_req = 1'b0;
      repeat (4) @(negedge clk);
      chk("R5 bus freed in pause", {31'd0, bus_req}, 32'd0);
      chk("R5 no strobes in pause", rd_cnt, 2);
      rd_reg(2'd3, v);
      chk("R5 busy in pause", {31'd0, v[6]}, 32'd1);
      per_req = 1'b1;
      wait_done("R5 demand");
      chk("R5 units moved", wr_cnt, 4);
      chk("R5 one release", drops, 1);
      for (int k = 0; k < 4; k++)
         chk("R5 peripheral data order", {16'd0, per_log[k]}, {16'd0, 16'hA030 + 16'(k)});
      per_req = 1'b0;
   endtask

   task automatic t_eop();
      logic [31:0] v;
      int n = 0;
      clear_mon();
      for (int k = 0; k < 8; k++) mem[8'hA0 + k] = '0;
      wr_reg(2'd0, 32'h0020);
      wr_reg(2'd1, 32'h0140);
      wr_reg(2'd2, 32'd8);
      wr_reg(2'd3, 32'h1D);
      while (!(bus_wr === 1'b1 && wr_cnt == 2) && n < 100) begin
         @(negedge clk);
         n++;
      end
      eop = 1'b1;
      @(negedge clk);
      eop = 1'b0;
      wait_done("R7 eop");
      chk("R7 units before stop", wr_cnt, 3);
      rd_reg(2'd2, v);
      chk("R7 remaining count", v, 32'd5);
      chk("R7 last unit written", {16'd0, mem[8'hA2]}, 32'h0000A012);
      chk("R7 next unit untouched", {16'd0, mem[8'hA3]}, 32'd0);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      clear_mon();
      wr_reg(2'd2, 32'd0);
      wr_reg(2'd3, 32'h05);
      chk("R11 immediate pulse", {31'd0, done_pulse}, 32'd1);
      @(negedge clk);
      chk("R8 pulse one cycle", {31'd0, done_pulse}, 32'd0);
      repeat (8) @(negedge clk);
      chk("R11 no bus request", req_hi, 0);
      rd_reg(2'd3, v);
      chk("R11 done set", {31'd0, v[5]}, 32'd1);
   endtask

   task automatic t_busy();
      logic [31:0] v;
      clear_mon();
      gnt_allow = 1'b0;
      wr_reg(2'd0, 32'h0000);
      wr_reg(2'd1, 32'h01C0);
      wr_reg(2'd2, 32'd2);
      wr_reg(2'd3, 32'h1D);
      repeat (3) @(negedge clk);
      chk("R10 request while waiting", {31'd0, bus_req}, 32'd1);
      chk("R10 no strobes without grant", rd_cnt + wr_cnt, 0);
      rd_reg(2'd3, v);
      chk("R8 done cleared busy set", {30'd0, v[6], v[5]}, 32'd2);
      wr_reg(2'd0, 32'h00F0);
      rd_reg(2'd0, v);
      chk("R9 src write ignored", v, 32'h0000);
      wr_reg(2'd2, 32'd7);
      rd_reg(2'd2, v);
      chk("R9 count write ignored", v, 32'd2);
      wr_reg(2'd3, 32'h03);
      rd_reg(2'd3, v);
      chk("R9 control write ignored", {27'd0, v[4:0]}, 32'h1C);
      gnt_allow = 1'b1;
      wait_done("R9 busy");
      chk("R9 data from original src 0", {16'd0, mem[8'hE0]}, 32'h0000A000);
      chk("R9 data from original src 1", {16'd0, mem[8'hE1]}, 32'h0000A001);
      chk("R9 unit count", wr_cnt, 2);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_block();
      t_single();
      t_demand();
      t_eop();
      t_zero();
      t_busy();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule